// File: doc/BRIEF.md
# Serial Port-Expander Front End

This block is the serial side of an 8-bit I/O port expander. A host frames each transaction with an active-low select and clocks bits in and out most significant bit first. The first byte of every frame is a command byte. Its top two bits form a device address that must equal two strapped identify inputs, so four expanders can hang off one select line. The rest of the command byte picks the register, the direction of transfer and the write format code, and every byte after it is a read or write of that register.

The serial clock, select and input data are oversampled by a faster system clock through two-flop synchronisers. When the select falls, the block records the idle level of the serial clock. For the rest of the frame, bits are launched on the edge that leaves the idle level and captured on the edge that returns to it. While the command byte arrives, the block returns a short status that ends with a compare flag captured from the port core at select fall. Register contents come from the port core on `rd_data_i`, and each completed write byte leaves as a one-cycle strobe carrying the byte, the register select and the format code.

Top module: `sps_port_front`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `miso_oe_o` and `wr_stb_o` are low.
- R2: The serial clock level seen when `cs_n_i` falls is the idle level. Each bit is driven on the edge away from that level and captured on the edge back to it, most significant bit first, whichever idle level is used.
- R3: Command bits 7:6 are compared with `id_strap_i` (bit 7 against `id_strap_i[1]`). On a mismatch the block never drives `miso_oe_o` and never strobes for the rest of that frame.
- R4: `miso_oe_o` is low while `cs_n_i` is high and during the first two bit slots of the command byte.
- R5: In command-byte slots 5 down to 1, `miso_o` returns command bits 7 down to 3. In slot 0 it returns the level of `cmp_flag_i` captured when `cs_n_i` fell.
- R6: Command bit 4 low selects a read. Every data byte returns `rd_data_i` as it stood at that byte's first launch edge, for as many bytes as the select stays low.
- R7: Command bit 4 high selects a write. The first data byte returns the old `rd_data_i`. After its eighth bit is captured, `wr_stb_o` pulses for one cycle with `wr_data_o` set to the byte, `reg_sel_o` set to command bit 5 (0 for the data register, 1 for the direction register) and `wr_fmt_o` set to command bits 3:2. After that, `miso_oe_o` is low.
- R8: Each further full byte in a write frame gives one more strobe, and `miso_oe_o` stays low while it is shifted.
- R9: If `cs_n_i` rises before a data byte is complete, that partial byte produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data from host |
| id_strap_i | input | 2 | Strapped device address |
| cmp_flag_i | input | 1 | Compare flag from the port core |
| rd_data_i | input | 8 | Contents of the selected register |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Drive enable for `miso_o` (low means high impedance) |
| reg_sel_o | output | 1 | Register select from the command byte |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Byte to write |
| wr_fmt_o | output | 2 | Write format code from the command byte |

## Verification
The assertions assume the inputs change slowly compared with `clk`. The select must stay put for at least three system cycles around each change, and the serial clock must hold each level for several cycles, so that the bounded look-back on `cs_n_i` and the one-cycle strobe property hold. The stimulus drives every input on the falling system edge. It holds each serial clock phase for eight system cycles and leaves four cycles of margin around select edges, so no synchroniser ever sees two changes inside its own delay.

// File: rtl/sps_pkg.sv
// Shared types and command-byte field positions for the serial front end.
// Assumes a byte-wide frame; positions are fixed by the host protocol.
package sps_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_READ,
        PH_WRITE,
        PH_MUTE
    } phase_t;

    localparam int CB_RS     = 5;
    localparam int CB_RW     = 4;
    localparam int CB_FMT_HI = 3;
    localparam int CB_FMT_LO = 2;
endpackage

// File: rtl/sps_sync.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherence is implied.
module sps_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // two register stages per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/sps_edge.sv
// Classifies synchronised select and clock changes into frame start/end and
// launch/capture pulses. The clock idle level is latched at select fall.
// Assumes the serial clock holds each level for at least two system cycles.
module sps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sck_s,
    output logic frame_start,
    output logic frame_end,
    output logic launch_p,
    output logic sample_p
);
    logic cs_d;
    logic sck_d;
    logic idle_lvl_q;
    logic sck_moved;

    // delayed copies for edge detection and the latched idle level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d       <= 1'b1;
            sck_d      <= 1'b0;
            idle_lvl_q <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
            if (cs_d && !cs_s)
                idle_lvl_q <= sck_s;
        end
    end

    // edge classification inside an active frame
    always_comb begin
        frame_start = cs_d && !cs_s;
        frame_end   = !cs_d && cs_s;
        sck_moved   = (sck_s != sck_d) && !cs_s && !cs_d;
        launch_p    = sck_moved && (sck_s != idle_lvl_q);
        sample_p    = sck_moved && (sck_s == idle_lvl_q);
    end
endmodule

// File: rtl/sps_frame.sv
// Frame sequencer: collects the command byte, checks the device address,
// returns status, then streams reads or issues write strobes per byte.
// Assumes launch and sample pulses alternate and never coincide with frame edges.
module sps_frame #(
    parameter int W    = 8,
    parameter int ID_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 launch_p,
    input  logic                 sample_p,
    input  logic                 mosi_s,
    input  logic [ID_W-1:0]      id_strap_i,
    input  logic                 cmp_flag_i,
    input  logic [W-1:0]         rd_data_i,
    output logic                 miso_o,
    output logic                 miso_oe_o,
    output logic                 reg_sel_o,
    output logic                 wr_stb_o,
    output logic [W-1:0]         wr_data_o,
    output logic [1:0]           wr_fmt_o
);
    import sps_pkg::*;

    localparam int              CNT_W   = $clog2(W);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] ID_SLOT = CNT_W'(W - ID_W);

    phase_t           phase;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     in_sr;
    logic [W-1:0]     out_sr;
    logic [W-1:0]     rx_byte;
    logic             miso_q;
    logic             oe_q;
    logic             flag_q;
    logic             rs_q;
    logic [1:0]       fmt_q;
    logic             first_q;
    logic             stb_q;
    logic [W-1:0]     wdata_q;

    // byte as it stands including the bit being captured now
    assign rx_byte = {in_sr[W-2:0], mosi_s};

    // frame sequencing, shifting and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= LAST;
            in_sr   <= '0;
            out_sr  <= '0;
            miso_q  <= 1'b0;
            oe_q    <= 1'b0;
            flag_q  <= 1'b0;
            rs_q    <= 1'b0;
            fmt_q   <= '0;
            first_q <= 1'b0;
            stb_q   <= 1'b0;
            wdata_q <= '0;
        end else begin
            stb_q <= 1'b0;
            if (frame_end) begin
                phase <= PH_IDLE;
                oe_q  <= 1'b0;
            end else if (frame_start) begin
                phase   <= PH_CTRL;
                bit_cnt <= LAST;
                flag_q  <= cmp_flag_i;
                oe_q    <= 1'b0;
            end else if (launch_p) begin
                case (phase)
                    PH_CTRL: begin
                        if (bit_cnt < ID_SLOT) begin
                            oe_q   <= 1'b1;
                            miso_q <= (bit_cnt == '0) ? flag_q : in_sr[ID_W-1];
                        end
                    end
                    PH_READ, PH_WRITE: begin
                        if (bit_cnt == LAST) begin
                            miso_q <= rd_data_i[W-1];
                            out_sr <= {rd_data_i[W-2:0], 1'b0};
                            oe_q   <= (phase == PH_READ) || first_q;
                        end else begin
                            miso_q <= out_sr[W-1];
                            out_sr <= {out_sr[W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end else if (sample_p) begin
                in_sr   <= rx_byte;
                bit_cnt <= (bit_cnt == '0) ? LAST : bit_cnt - 1'b1;
                case (phase)
                    PH_CTRL: begin
                        if (bit_cnt == ID_SLOT && rx_byte[ID_W-1:0] != id_strap_i) begin
                            phase <= PH_MUTE;
                            oe_q  <= 1'b0;
                        end else if (bit_cnt == '0) begin
                            rs_q    <= rx_byte[CB_RS];
                            fmt_q   <= rx_byte[CB_FMT_HI:CB_FMT_LO];
                            phase   <= rx_byte[CB_RW] ? PH_WRITE : PH_READ;
                            first_q <= 1'b1;
                        end
                    end
                    PH_WRITE: begin
                        if (bit_cnt == '0) begin
                            stb_q   <= 1'b1;
                            wdata_q <= rx_byte;
                            first_q <= 1'b0;
                            oe_q    <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso_o    = miso_q;
    assign miso_oe_o = oe_q;
    assign reg_sel_o = rs_q;
    assign wr_fmt_o  = fmt_q;
    assign wr_stb_o  = stb_q;
    assign wr_data_o = wdata_q;
endmodule

// File: rtl/sps_port_front.sv
// Top of the serial front end: synchronisers, edge classifier, frame sequencer.
// Assumes the serial clock runs at most a quarter of the system clock rate.
module sps_port_front #(
    parameter int W    = 8,
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_i,
    input  logic            sck_i,
    input  logic            mosi_i,
    input  logic [ID_W-1:0] id_strap_i,
    input  logic            cmp_flag_i,
    input  logic [W-1:0]    rd_data_i,
    output logic            miso_o,
    output logic            miso_oe_o,
    output logic            reg_sel_o,
    output logic            wr_stb_o,
    output logic [W-1:0]    wr_data_o,
    output logic [1:0]      wr_fmt_o
);
    logic [2:0] raw_in;
    logic [2:0] sync_out;
    logic       cs_s;
    logic       sck_s;
    logic       mosi_s;
    logic       frame_start;
    logic       frame_end;
    logic       launch_p;
    logic       sample_p;

    assign raw_in = {cs_n_i, sck_i, mosi_i};
    assign {cs_s, sck_s, mosi_s} = sync_out;

    sps_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    sps_edge i_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sck_s       (sck_s),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .launch_p    (launch_p),
        .sample_p    (sample_p)
    );

    sps_frame #(.W(W), .ID_W(ID_W)) i_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .launch_p    (launch_p),
        .sample_p    (sample_p),
        .mosi_s      (mosi_s),
        .id_strap_i  (id_strap_i),
        .cmp_flag_i  (cmp_flag_i),
        .rd_data_i   (rd_data_i),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o),
        .reg_sel_o   (reg_sel_o),
        .wr_stb_o    (wr_stb_o),
        .wr_data_o   (wr_data_o),
        .wr_fmt_o    (wr_fmt_o)
    );
endmodule

// File: rtl/sps_port_front_chk.sv
// Property checker bound to the front-end top.
// Assumes select edges are at least three system cycles apart.
module sps_port_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic miso_oe_o,
    input logic wr_stb_o,
    input logic launch_p,
    input logic sample_p
);
    // R1: reset leaves the line undriven and no strobe
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!miso_oe_o && !wr_stb_o));

    // R4: select held high long enough means no drive
    a_r4_z_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !miso_oe_o);

    // R2: drive only begins on a launch edge
    a_r2_drive_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe_o) |-> $past(launch_p));

    // R2: a strobe only follows a capture edge
    a_r2_strobe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(sample_p));

    // R7: the strobe lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R7: line is released once a write byte lands
    a_r7_z_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !miso_oe_o);
endmodule

bind sps_port_front sps_port_front_chk i_chk (.*);

// File: tb/test_sps_port_front.sv
module test_sps_port_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic [1:0] strap = 2'b00;
    logic       cmp_flag = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       miso_o;
    logic       miso_oe_o;
    logic       reg_sel_o;
    logic       wr_stb_o;
    logic [7:0] wr_data_o;
    logic [1:0] wr_fmt_o;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    logic [7:0] stb_data = 8'h00;
    logic [1:0] stb_fmt = 2'b00;
    logic       stb_rs = 1'b0;

    always #2 clk = ~clk;

    sps_port_front i_sps_port_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .mosi_i     (mosi),
        .id_strap_i (strap),
        .cmp_flag_i (cmp_flag),
        .rd_data_i  (rd_data),
        .miso_o     (miso_o),
        .miso_oe_o  (miso_oe_o),
        .reg_sel_o  (reg_sel_o),
        .wr_stb_o   (wr_stb_o),
        .wr_data_o  (wr_data_o),
        .wr_fmt_o   (wr_fmt_o)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && wr_stb_o) begin
            stb_cnt  <= stb_cnt + 1;
            stb_data <= wr_data_o;
            stb_fmt  <= wr_fmt_o;
            stb_rs   <= reg_sel_o;
        end
    end

    typedef struct packed {
        logic       cpol;
        logic [1:0] strap;
        logic [7:0] ctrl;
        logic [7:0] data;
        logic [7:0] rd;
        logic       flag;
    } vec_t;

    localparam vec_t VECS [6] = '{
        {1'b0, 2'b01, 8'h54, 8'hA5, 8'h3C, 1'b1},
        {1'b1, 2'b01, 8'h40, 8'h00, 8'hC3, 1'b0},
        {1'b0, 2'b10, 8'hBB, 8'h0F, 8'h81, 1'b0},
        {1'b1, 2'b11, 8'hE1, 8'hFF, 8'h5A, 1'b1},
        {1'b1, 2'b00, 8'h1C, 8'hF0, 8'h77, 1'b1},
        {1'b0, 2'b11, 8'h50, 8'h55, 8'h99, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    logic cur_cpol = 1'b0;

    task automatic begin_frame(input logic cpol, input logic flag);
        @(negedge clk);
        cur_cpol = cpol;
        sck = cpol;
        cmp_flag = flag;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        cmp_flag = ~flag;
    endtask

    task automatic end_frame();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output logic [7:0] oe);
        rx = 8'h00;
        oe = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sck = ~cur_cpol;
            mosi = tx[i];
            repeat (7) @(negedge clk);
            rx[i] = miso_o;
            oe[i] = miso_oe_o;
            @(negedge clk);
            sck = cur_cpol;
            repeat (7) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] rx;
        logic [7:0] oe;
        int base;

        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1 oe in reset", {7'd0, miso_oe_o}, 8'h00);
        check("R1 strobe in reset", {7'd0, wr_stb_o}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 oe after reset", {7'd0, miso_oe_o}, 8'h00);

        // table-driven frames: R2..R7
        for (int v = 0; v < 6; v++) begin
            logic match;
            logic [7:0] exp_oe;
            strap   = VECS[v].strap;
            rd_data = VECS[v].rd;
            match   = (VECS[v].ctrl[7:6] == VECS[v].strap);
            base    = stb_cnt;
            begin_frame(VECS[v].cpol, VECS[v].flag);
            xfer(VECS[v].ctrl, 8, rx, oe);
            exp_oe = match ? 8'h3F : 8'h00;
            check("R4 R3 command-byte drive", oe, exp_oe);
            check("R5 R2 status bits", rx & exp_oe,
                  {2'b00, VECS[v].ctrl[7:3], VECS[v].flag} & exp_oe);
            xfer(VECS[v].data, 8, rx, oe);
            check("R3 data-byte drive", oe, match ? 8'hFF : 8'h00);
            if (match)
                check("R6 R7 returned register", rx, VECS[v].rd);
            repeat (2) @(negedge clk);
            if (match && VECS[v].ctrl[4]) begin
                check("R7 one strobe", 8'(stb_cnt - base), 8'd1);
                check("R7 strobe data", stb_data, VECS[v].data);
                check("R7 strobe fmt and select", {5'd0, stb_rs, stb_fmt},
                      {5'd0, VECS[v].ctrl[5], VECS[v].ctrl[3:2]});
                check("R7 released after write", {7'd0, miso_oe_o}, 8'h00);
            end else begin
                check("R3 R6 no strobe", 8'(stb_cnt - base), 8'd0);
                check("R6 drive held in read", {7'd0, miso_oe_o}, {7'd0, match});
            end
            end_frame();
            check("R4 idle after frame", {7'd0, miso_oe_o}, 8'h00);
        end

        // R6: continuous read of changing contents
        strap = 2'b10;
        rd_data = 8'hA1;
        begin_frame(1'b0, 1'b0);
        xfer(8'h80, 8, rx, oe);
        xfer(8'h00, 8, rx, oe);
        check("R6 read byte 1", rx, 8'hA1);
        rd_data = 8'hB2;
        xfer(8'h00, 8, rx, oe);
        check("R6 read byte 2", rx, 8'hB2);
        rd_data = 8'hC3;
        xfer(8'h00, 8, rx, oe);
        check("R6 read byte 3", rx, 8'hC3);
        check("R6 drive byte 3", oe, 8'hFF);
        end_frame();

        // R8: multi-byte write
        base = stb_cnt;
        rd_data = 8'h44;
        begin_frame(1'b1, 1'b1);
        xfer(8'h90, 8, rx, oe);
        xfer(8'h11, 8, rx, oe);
        check("R7 old contents out", rx, 8'h44);
        xfer(8'h22, 8, rx, oe);
        check("R8 no drive on later byte", oe, 8'h00);
        repeat (2) @(negedge clk);
        check("R8 two strobes", 8'(stb_cnt - base), 8'd2);
        check("R8 last data", stb_data, 8'h22);
        end_frame();

        // R9: abort mid data byte
        base = stb_cnt;
        begin_frame(1'b0, 1'b0);
        xfer(8'h90, 8, rx, oe);
        xfer(8'hF0, 4, rx, oe);
        end_frame();
        repeat (20) @(negedge clk);
        check("R9 partial byte no strobe", 8'(stb_cnt - base), 8'd0);
        check("R9 line released", {7'd0, miso_oe_o}, 8'h00);

        finish_run();
    end
endmodule